// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer

This block turns the command bits of two independent half-bridges (A and B) into four gate-enable outputs. Each half takes a low-side command and a high-side command and drives a low-side gate enable and a high-side gate enable. When both commands of a half are high, the low-side command wins. This rule prevents shoot-through. Every gate turns off as soon as its request goes away. A turn-on waits a programmed number of clock cycles, with one delay shared by both high sides and a second delay shared by both low sides. These turn-on waits form the dead time between the two switches of a half.

Holding the high-side command high puts a half in bistate operation. The low-side command alone then toggles the two gates in complementary fashion, with dead time on every turn-on edge. A disable input or an undervoltage flag forces all four gates low. When the last of them is released, both low-side gates pulse high for a fixed number of cycles so that the bootstrap capacitors can recharge. The high-side gates stay blocked until a longer wake interval has passed. Reset starts the same wake sequence. All command inputs pass through a two-flop synchronizer first.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: While the synchronized disable is high, all four gate outputs are low. An output goes low two cycles after the disable input rises.
- R2: The undervoltage flag forces all four outputs low in exactly the same way as disable.
- R3: In a half whose low-side command is high, the low-side gate is high and the high-side gate is low, whatever the high-side command is.
- R4: With the low-side command low, a high high-side command gives high-side gate high and low-side gate low. With both commands low, both gates of that half are low.
- R5: A gate goes low in the same cycle that its synchronized request drops, which is two clock edges after the input changes. No delay is added.
- R6: A low-side gate rises LOW_ON_DLY cycles after its synchronized request rises, and a high-side gate rises HIGH_ON_DLY cycles after. Counted from the input, this is 2 + delay clock edges. Both delay values are loaded into registers at reset.
- R7: A request that drops before its delay expires cancels the count, and the gate never rises.
- R8: With the high-side command held high, the low-side command alone drives the pair in complementary fashion. Each turn-on edge follows the opposite turn-off by that side's delay, and the two gates of a half are never high together.
- R9: On release from disable, undervoltage or reset, both low-side gates are high for REFRESH_CYC cycles. The pulse starts 3 clock edges after the release reaches the input.
- R10: High-side gates stay low until UPPER_EN_CYC cycles after the refresh start. A held high-side request first shows at edge 3 + UPPER_EN_CYC + HIGH_ON_DLY after the release.
- R11: Synchronous reset drives all outputs low and restarts the refresh and wake sequence as if disable had just been released.
- R12: Halves A and B act independently. A change on one half's commands never alters the other half's gates.
- R13: Command inputs reach the gate logic through a two-flop synchronizer, so a change has no effect at the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| disableReq | input | 1 | Forces all gates low while high |
| uvFault | input | 1 | Undervoltage flag, forces all gates low while high |
| loCmdA | input | 1 | Half A low-side command |
| hiCmdA | input | 1 | Half A high-side command |
| loCmdB | input | 1 | Half B low-side command |
| hiCmdB | input | 1 | Half B high-side command |
| gateLoA | output | 1 | Half A low-side gate enable |
| gateHiA | output | 1 | Half A high-side gate enable |
| gateLoB | output | 1 | Half B low-side gate enable |
| gateHiB | output | 1 | Half B high-side gate enable |

## Verification
The bench aims at the exact edge of each turn-on. A design with an off-by-one counter shows the gate one cycle early or late, and that shrinks or stretches the dead time. Short request pulses test cancellation: a counter that is not cleared would let a later pulse fire early, or a stale count would produce a glitch. Both commands high, with bistate toggling, tests the low-side priority: a wrong priority turns both gates of a half on together. Repeated release from disable, undervoltage and reset tests the refresh width and the wake interval: a design that skips the sequence lets the high side on too soon.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
  // Phases of the wake sequencer
  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_WAKE = 2'd1,
    PH_RUN  = 2'd2
  } hb_phase_t;

  // Strobes from control to the half-bridge datapath
  typedef struct packed {
    logic blocked;
    logic refresh;
    logic upperEn;
  } hb_strobe_t;
endpackage

// File: rtl/hb_sync.sv
`timescale 1ns/1ps
module hb_sync #(
  parameter int W = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/hb_ctrl.sv
`timescale 1ns/1ps
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int REFRESH_CYC  = 8,
  parameter int UPPER_EN_CYC = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       disS,
  input  logic       uvS,
  output hb_strobe_t strobe
);
  localparam int SEQ_W = $clog2(UPPER_EN_CYC + 1);

  hb_phase_t  phase;
  logic [SEQ_W-1:0] seqCnt;
  logic blocked;

  assign blocked = disS | uvS;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_HOLD;
      seqCnt <= '0;
    end else if (blocked) begin
      phase  <= PH_HOLD;
      seqCnt <= '0;
    end else begin
      case (phase)
        PH_HOLD: begin
          phase  <= PH_WAKE;
          seqCnt <= '0;
        end
        PH_WAKE: begin
          if (seqCnt == SEQ_W'(UPPER_EN_CYC - 1)) phase <= PH_RUN;
          else seqCnt <= seqCnt + 1'b1;
        end
        PH_RUN:  phase <= PH_RUN;
        default: phase <= PH_HOLD;
      endcase
    end
  end

  assign strobe.blocked = blocked;
  assign strobe.refresh = (phase == PH_WAKE) && (seqCnt < SEQ_W'(REFRESH_CYC)) && !blocked;
  assign strobe.upperEn = (phase == PH_RUN) && !blocked;

  // R9 / R10: the refresh pulse and the high-side enable never overlap
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(strobe.refresh && strobe.upperEn));

  // R10: the high-side enable only opens at the end of a wake interval
  a_r10_enable_after_wake: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe.upperEn) |-> $past(phase == PH_WAKE));
endmodule

// File: rtl/hb_delay.sv
`timescale 1ns/1ps
module hb_delay #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] dly,
  input  logic             req,
  output logic             on
);
  logic [CNT_W-1:0] cnt;

  // Count while requested, saturate at the delay, clear at once on drop
  always_ff @(posedge clk) begin
    if (rst || !req) cnt <= '0;
    else if (cnt < dly) cnt <= cnt + 1'b1;
  end

  assign on = req && (cnt >= dly);

  // R6: with a nonzero delay, a turn-on needs the request in the prior cycle
  a_r6_min_delay: assert property (@(posedge clk) disable iff (rst)
    ((dly != '0) && $rose(on)) |-> $past(req));
endmodule

// File: rtl/hb_leg.sv
`timescale 1ns/1ps
module hb_leg
  import hb_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loS,
  input  logic             hiS,
  input  hb_strobe_t       strobe,
  input  logic [CNT_W-1:0] dlyLo,
  input  logic [CNT_W-1:0] dlyHi,
  output logic             gateLo,
  output logic             gateHi
);
  logic reqLo, reqHi, loOn, hiOn;

  // Low-side command has priority over the high-side command
  assign reqLo = loS && !strobe.blocked;
  assign reqHi = hiS && !loS && !strobe.blocked && strobe.upperEn;

  hb_delay #(.CNT_W(CNT_W)) u_loDly (
    .clk(clk), .rst(rst), .dly(dlyLo), .req(reqLo), .on(loOn));

  hb_delay #(.CNT_W(CNT_W)) u_hiDly (
    .clk(clk), .rst(rst), .dly(dlyHi), .req(reqHi), .on(hiOn));

  assign gateLo = loOn || strobe.refresh;
  assign gateHi = hiOn;

  // R3: a high low-side command keeps the high-side gate off
  a_r3_low_wins: assert property (@(posedge clk) disable iff (rst)
    loS |-> !gateHi);

  // R1 / R2: disable or undervoltage holds both gates low
  a_r1_blocked_low: assert property (@(posedge clk) disable iff (rst)
    strobe.blocked |-> (!gateLo && !gateHi));

  // R8: the two gates of a half are never high together
  a_r8_no_shoot: assert property (@(posedge clk) disable iff (rst)
    !(gateLo && gateHi));
endmodule

// File: rtl/bridge_gate_ctrl.sv
`timescale 1ns/1ps
module bridge_gate_ctrl
  import hb_pkg::*;
#(
  parameter int HIGH_ON_DLY  = 5,
  parameter int LOW_ON_DLY   = 3,
  parameter int REFRESH_CYC  = 8,
  parameter int UPPER_EN_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic disableReq,
  input  logic uvFault,
  input  logic loCmdA,
  input  logic hiCmdA,
  input  logic loCmdB,
  input  logic hiCmdB,
  output logic gateLoA,
  output logic gateHiA,
  output logic gateLoB,
  output logic gateHiB
);
  localparam int NUM_HALF = 2;
  localparam int MAX_DLY  = (HIGH_ON_DLY > LOW_ON_DLY) ? HIGH_ON_DLY : LOW_ON_DLY;
  localparam int CNT_W    = (MAX_DLY < 1) ? 1 : $clog2(MAX_DLY + 1);
  localparam int SYNC_W   = 2 * NUM_HALF + 2;
  // disable and undervoltage come out of reset asserted, so reset looks like a release
  localparam logic [SYNC_W-1:0] SYNC_RST = {2'b11, {(2*NUM_HALF){1'b0}}};

  logic [SYNC_W-1:0] syncQ;
  logic [CNT_W-1:0]  hiDlyQ, loDlyQ;
  hb_strobe_t        strobe;
  logic [NUM_HALF-1:0] loS, hiS, gLo, gHi;

  // R13: two-flop synchronizer on every command
  hb_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d({uvFault, disableReq, hiCmdB, loCmdB, hiCmdA, loCmdA}),
    .q(syncQ));

  // R6: turn-on delays held in registers loaded at reset
  always_ff @(posedge clk) begin
    if (rst) begin
      hiDlyQ <= CNT_W'(HIGH_ON_DLY);
      loDlyQ <= CNT_W'(LOW_ON_DLY);
    end
  end

  hb_ctrl #(.REFRESH_CYC(REFRESH_CYC), .UPPER_EN_CYC(UPPER_EN_CYC)) u_ctrl (
    .clk(clk), .rst(rst),
    .disS(syncQ[2*NUM_HALF]), .uvS(syncQ[2*NUM_HALF+1]),
    .strobe(strobe));

  generate
    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
      assign loS[h] = syncQ[2*h];
      assign hiS[h] = syncQ[2*h+1];
      hb_leg #(.CNT_W(CNT_W)) u_leg (
        .clk(clk), .rst(rst),
        .loS(loS[h]), .hiS(hiS[h]),
        .strobe(strobe),
        .dlyLo(loDlyQ), .dlyHi(hiDlyQ),
        .gateLo(gLo[h]), .gateHi(gHi[h]));
    end
  endgenerate

  assign gateLoA = gLo[0];
  assign gateHiA = gHi[0];
  assign gateLoB = gLo[1];
  assign gateHiB = gHi[1];
endmodule

// File: tb/tb_bridge_gate_ctrl.sv
`timescale 1ns/1ps
module tb_bridge_gate_ctrl;
  localparam int HI   = 5;
  localparam int LO   = 3;
  localparam int REF  = 8;
  localparam int UPEN = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disableReq = 1'b0, uvFault = 1'b0;
  logic loCmdA = 1'b0, hiCmdA = 1'b0, loCmdB = 1'b0, hiCmdB = 1'b0;
  logic gateLoA, gateHiA, gateLoB, gateHiB;

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;
  bit chkOn = 1'b0;
  string curTag = "R11";

  always #2.5 clk = ~clk;

  bridge_gate_ctrl #(.HIGH_ON_DLY(HI), .LOW_ON_DLY(LO),
                     .REFRESH_CYC(REF), .UPPER_EN_CYC(UPEN)) dut (
    .clk(clk), .rst(rst), .disableReq(disableReq), .uvFault(uvFault),
    .loCmdA(loCmdA), .hiCmdA(hiCmdA), .loCmdB(loCmdB), .hiCmdB(hiCmdB),
    .gateLoA(gateLoA), .gateHiA(gateHiA), .gateLoB(gateLoB), .gateHiB(gateHiB));

  // ---------------- reference model from the requirements ----------------
  // bit order of command vector: 0 loA, 1 hiA, 2 loB, 3 hiB, 4 disable, 5 undervoltage
  bit [5:0] ms1 = 6'b110000;
  bit [5:0] ms2 = 6'b110000;
  int relAge = -1;          // cycles since release, -1 while blocked
  int mCnt [4] = '{0, 0, 0, 0};

  function automatic bit mBlk();
    return ms2[4] | ms2[5];
  endfunction

  function automatic bit mReq(int i);
    bit up = !mBlk() && (relAge >= UPEN);
    case (i)
      0: return ms2[0] && !mBlk();
      1: return ms2[1] && !ms2[0] && !mBlk() && up;
      2: return ms2[2] && !mBlk();
      default: return ms2[3] && !ms2[2] && !mBlk() && up;
    endcase
  endfunction

  function automatic int mDly(int i);
    return (i % 2 == 0) ? LO : HI;
  endfunction

  // expected {hiB, loB, hiA, loA}
  function automatic logic [3:0] expOut();
    logic [3:0] e;
    bit refr = !mBlk() && (relAge >= 0) && (relAge < REF);
    for (int i = 0; i < 4; i++) e[i] = mReq(i) && (mCnt[i] >= mDly(i));
    e[0] = e[0] | refr;
    e[2] = e[2] | refr;
    return e;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ms1 = 6'b110000;
      ms2 = 6'b110000;
      relAge = -1;
      for (int i = 0; i < 4; i++) mCnt[i] = 0;
    end else begin
      bit blk = mBlk();
      bit rq [4];
      for (int i = 0; i < 4; i++) rq[i] = mReq(i);
      for (int i = 0; i < 4; i++) begin
        if (!rq[i]) mCnt[i] = 0;
        else if (mCnt[i] < mDly(i)) mCnt[i] = mCnt[i] + 1;
      end
      if (blk) relAge = -1;
      else if (relAge < 0) relAge = 0;
      else if (relAge < UPEN) relAge = relAge + 1;
      ms2 = ms1;
      ms1 = {uvFault, disableReq, hiCmdB, loCmdB, hiCmdA, loCmdA};
    end
  end

  function automatic logic [3:0] actOut();
    return {gateHiB, gateLoB, gateHiA, gateLoA};
  endfunction

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (chkOn && !done) begin
      logic [3:0] e = expOut();
      logic [3:0] a = actOut();
      nChecks++;
      if (a !== e) begin
        nErr++;
        $display("FAIL %s model compare: actual=%b expected=%b", curTag, a, e);
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // index into actOut(): 0 loA, 1 hiA, 2 loB, 3 hiB
  task automatic firstHigh(int sel, int maxK, output int k);
    k = -1;
    for (int n = 1; n <= maxK; n++) begin
      @(negedge clk);
      if (k < 0 && actOut()[sel]) k = n;
    end
  endtask

  task automatic countHigh(int sel, int nCyc, output int c);
    c = 0;
    for (int n = 1; n <= nCyc; n++) begin
      @(negedge clk);
      if (actOut()[sel]) c++;
    end
  endtask

  task automatic finishBench();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      nErr++;
      $display("FAIL watchdog expired");
      finishBench();
    end
  end

  initial begin
    int k, c, loFirst;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chkOn = 1'b1;
    chk(actOut() == 4'b0000, "R11 reset state", actOut(), 0);

    // R9 / R10 / R11: wake sequence after reset, high-side A request held
    hiCmdA = 1'b1;
    rst = 1'b0;
    curTag = "R9";
    loFirst = -1; k = -1; c = 0;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (gateLoA) begin c++; if (loFirst < 0) loFirst = n; end
      if (gateHiA && k < 0) k = n;
    end
    chk(loFirst == 3, "R9 refresh start", loFirst, 3);
    chk(c == REF, "R9 refresh width", c, REF);
    chk(k == 3 + UPEN + HI, "R10 high-side wake", k, 3 + UPEN + HI);

    // R6 / R13: low-side turn-on delay on half B
    curTag = "R6";
    loCmdB = 1'b1;
    firstHigh(2, 12, k);
    chk(k == 2 + LO, "R6 low-side delay", k, 2 + LO);
    loCmdB = 1'b0;
    @(negedge clk);
    chk(gateLoB == 1'b1, "R13 no effect at first edge", gateLoB, 1);
    @(negedge clk);
    chk(gateLoB == 1'b0, "R5 low-side off at once", gateLoB, 0);
    hiCmdB = 1'b1;
    firstHigh(3, 12, k);
    chk(k == 2 + HI, "R6 high-side delay", k, 2 + HI);
    hiCmdB = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(gateHiB == 1'b0, "R5 high-side off at once", gateHiB, 0);

    // R7: short requests are cancelled
    curTag = "R7";
    repeat (4) @(negedge clk);
    loCmdB = 1'b1;
    repeat (LO - 1) @(negedge clk);
    loCmdB = 1'b0;
    countHigh(2, 10, c);
    chk(c == 0, "R7 low-side cancel", c, 0);
    hiCmdB = 1'b1;
    repeat (HI - 1) @(negedge clk);
    hiCmdB = 1'b0;
    countHigh(3, 10, c);
    chk(c == 0, "R7 high-side cancel", c, 0);

    // R3: both commands high on A
    curTag = "R3";
    loCmdA = 1'b1;
    repeat (20) @(negedge clk);
    chk(gateHiA == 1'b0 && gateLoA == 1'b1, "R3 low-side priority", {gateHiA, gateLoA}, 1);

    // R8: bistate on A, dead time on each edge
    curTag = "R8";
    loCmdA = 1'b0;
    k = -1; c = 0;
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      if (n == 2 && gateLoA) c = 1;
      if (gateHiA && k < 0) k = n;
    end
    chk(c == 0, "R8 low-side off on fall", c, 0);
    chk(k == 2 + HI, "R8 high-side dead time", k, 2 + HI);
    loCmdA = 1'b1;
    k = -1; c = 0;
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      if (n == 2 && gateHiA) c = 1;
      if (gateLoA && k < 0) k = n;
    end
    chk(c == 0, "R8 high-side off on rise", c, 0);
    chk(k == 2 + LO, "R8 low-side dead time", k, 2 + LO);
    for (int t = 0; t < 8; t++) begin
      loCmdA = ~loCmdA;
      repeat (4 + t) @(negedge clk);
    end

    // R12: halves are independent
    curTag = "R12";
    loCmdA = 1'b1; hiCmdA = 1'b0; loCmdB = 1'b0; hiCmdB = 1'b1;
    repeat (15) @(negedge clk);
    chk(actOut() == 4'b1001, "R12 opposite halves", actOut(), 4'b1001);
    hiCmdB = 1'b0; loCmdB = 1'b1;
    for (int n = 0; n < 15; n++) begin
      @(negedge clk);
      if (!gateLoA || gateHiA) c = 99;
    end
    chk(c != 99, "R12 half A unaffected by B", c, 0);

    // R4: truth table on A
    curTag = "R4";
    loCmdA = 1'b0; hiCmdA = 1'b0;
    repeat (10) @(negedge clk);
    chk(gateLoA == 1'b0 && gateHiA == 1'b0, "R4 both low", {gateHiA, gateLoA}, 0);
    hiCmdA = 1'b1;
    repeat (10) @(negedge clk);
    chk(gateHiA == 1'b1 && gateLoA == 1'b0, "R4 high-side only", {gateHiA, gateLoA}, 2);

    // R1: disable overrides everything, then wake sequence again
    curTag = "R1";
    disableReq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(actOut() == 4'b0000, "R1 disable forces low", actOut(), 0);
    repeat (10) @(negedge clk);
    disableReq = 1'b0;
    curTag = "R10";
    loFirst = -1; k = -1;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (gateLoA && loFirst < 0) loFirst = n;
      if (gateHiA && k < 0) k = n;
    end
    chk(loFirst == 3, "R9 refresh after disable", loFirst, 3);
    chk(k == 3 + UPEN + HI, "R10 high-side after disable", k, 3 + UPEN + HI);

    // R2: undervoltage acts like disable
    curTag = "R2";
    uvFault = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(actOut() == 4'b0000, "R2 undervoltage forces low", actOut(), 0);
    repeat (6) @(negedge clk);
    uvFault = 1'b0;
    firstHigh(1, 40, k);
    chk(k == 3 + UPEN + HI, "R2 wake after undervoltage", k, 3 + UPEN + HI);

    // R11: reset mid-run restarts the sequence
    curTag = "R11";
    rst = 1'b1;
    @(negedge clk);
    chk(actOut() == 4'b0000, "R11 reset forces low", actOut(), 0);
    rst = 1'b0;
    firstHigh(1, 40, k);
    chk(k == 3 + UPEN + HI, "R11 wake after reset", k, 3 + UPEN + HI);

    // Constrained random against the model
    curTag = "R4 random";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if ($urandom % 6 == 0) loCmdA = ~loCmdA;
      if ($urandom % 6 == 0) hiCmdA = ~hiCmdA;
      if ($urandom % 6 == 0) loCmdB = ~loCmdB;
      if ($urandom % 6 == 0) hiCmdB = ~hiCmdB;
      if ($urandom % 97 == 0) disableReq = ~disableReq;
      if ($urandom % 131 == 0) uvFault = ~uvFault;
    end
    repeat (4) @(negedge clk);
    finishBench();
  end
endmodule